// File: doc/BRIEF.md
# Prover Run Gated Pulse Counter

This block measures one meter proving run. A flowmeter produces a train of pulses while a sphere travels through a calibrated section of pipe; a detector switch at each end of that section gives one pulse as the sphere passes. The block counts the meter pulses seen between the two detector pulses. That count is the meter's output for the known volume of the section.

A synchronous gate-enable input arms the block. The first rising edge on the detector line starts counting. The second rising edge stops it. The block then raises a finished flag and holds the count steady for a reader. The meter and detector lines are asynchronous to the clock. Each passes through a two-flop synchronizer before its rising edges are detected. A count that reaches its top value stops there and sets a sticky overflow flag. It does not wrap.

To take another run, software drops gate enable and raises it again. Dropping gate enable at any point abandons the run and returns the block to idle.

Top module: `prover_gate_counter`

## Requirements
- R1: After reset the block is idle: `run_count_o` is 0 and `running_o`, `finished_o` and `overflow_o` are all low.
- R2: Raising `gate_en_i` arms the block. While it is armed, meter pulses are not counted and `running_o` stays low.
- R3: While armed, the first detector rising edge sets `running_o`. A meter rising edge seen in the same cycle as that detector edge is not counted.
- R4: While running, every meter rising edge adds exactly one to `run_count_o`. A meter level held high adds only one. Each result appears two clock edges after the edge that first samples the input.
- R5: While running, the second detector rising edge clears `running_o` and sets `finished_o`. A meter rising edge seen in the same cycle as that detector edge is counted.
- R6: While `finished_o` is high and `gate_en_i` stays high, `run_count_o` and `finished_o` hold. Further meter and detector pulses have no effect on them.
- R7: Clearing `gate_en_i` returns the block to idle on the next edge. At that point `running_o` and `finished_o` are low and the last count is kept. A later rise of `gate_en_i` re-arms the block and clears `run_count_o` and `overflow_o` to 0.
- R8: The count saturates at 2^CNT_W-1. A meter edge that arrives while the count is at that value sets `overflow_o`, which stays high until the next arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en_i | input | 1 | Synchronous run enable; a rise arms, a fall aborts or releases |
| meter_i | input | 1 | Asynchronous meter pulse line |
| detector_i | input | 1 | Asynchronous detector switch pulse line |
| run_count_o | output | CNT_W | Meter pulses counted in the current or last run |
| running_o | output | 1 | High between the first and second detector edges |
| finished_o | output | 1 | High once the run is complete and the count is valid |
| overflow_o | output | 1 | Sticky: at least one pulse was lost to saturation |

## Verification
Meter and detector inputs are driven on the falling clock edge. The first rising edge then captures them. Two further rising edges pass them through the second synchronizer flop and into the state and count registers. The counter or state therefore changes on the second rising edge after capture. Gate enable is synchronous and acts on the first rising edge. Every bench scenario waits at least three full cycles after its last input change before sampling. Samples are taken on the falling edge. Cases where two pulses share a cycle are driven with both inputs changing at the same falling edge, so both are captured on the same rising edge.

// File: rtl/prover_pkg.sv
package prover_pkg;

    typedef enum logic [1:0] {
        PS_IDLE     = 2'd0,
        PS_ARMED    = 2'd1,
        PS_COUNTING = 2'd2,
        PS_DONE     = 2'd3
    } prover_state_t;

    typedef struct packed {
        prover_state_t state;
        logic          gate_seen;
    } prover_ctrl_t;

    localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/prover_edge_sync.sv
module prover_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                r_d       = r_q;
                r_d.chain = {r_q.chain[STAGES-2:0], async_i};
                r_d.prev  = r_q.chain[LAST];
            end
        end else begin : g_single
            always_comb begin
                r_d       = r_q;
                r_d.chain = async_i;
                r_d.prev  = r_q.chain[LAST];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign level_o = r_q.chain[LAST];
    assign rise_o  = r_q.chain[LAST] & ~r_q.prev;
endmodule

// File: rtl/prover_sat_counter.sv
module prover_sat_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_regs_t;

    cnt_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_i) begin
            c_d.cnt = '0;
            c_d.ovf = 1'b0;
        end else if (inc_i) begin
            if (c_q.cnt == CNT_MAX) c_d.ovf = 1'b1;
            else                    c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count_o = c_q.cnt;
    assign ovf_o   = c_q.ovf;
endmodule

// File: rtl/prover_run_fsm.sv
module prover_run_fsm
    import prover_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en_i,
    input  logic meter_rise_i,
    input  logic det_rise_i,
    output logic clr_o,
    output logic inc_o,
    output logic running_o,
    output logic finished_o
);
    prover_ctrl_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        clr_o     = 1'b0;
        inc_o     = 1'b0;
        s_d.gate_seen = gate_en_i;
        unique case (s_q.state)
            PS_IDLE: begin
                if (gate_en_i) begin
                    s_d.state = PS_ARMED;
                    clr_o     = 1'b1;
                end
            end
            PS_ARMED: begin
                if (!gate_en_i)      s_d.state = PS_IDLE;
                else if (det_rise_i) s_d.state = PS_COUNTING;
            end
            PS_COUNTING: begin
                if (!gate_en_i) begin
                    s_d.state = PS_IDLE;
                end else begin
                    inc_o = meter_rise_i;
                    if (det_rise_i) s_d.state = PS_DONE;
                end
            end
            PS_DONE: begin
                if (!gate_en_i) s_d.state = PS_IDLE;
            end
            default: s_d.state = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: PS_IDLE, gate_seen: 1'b0};
        else        s_q <= s_d;
    end

    assign running_o  = (s_q.state == PS_COUNTING);
    assign finished_o = (s_q.state == PS_DONE);
endmodule

// File: rtl/prover_gate_counter.sv
module prover_gate_counter
    import prover_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en_i,
    input  logic             meter_i,
    input  logic             detector_i,
    output logic [CNT_W-1:0] run_count_o,
    output logic             running_o,
    output logic             finished_o,
    output logic             overflow_o
);
    logic meter_lvl, meter_rise;
    logic det_lvl, det_rise;
    logic cnt_clr, cnt_inc;

    prover_edge_sync #(.STAGES(SYNC_STAGES)) u_meter_sync (
        .clk(clk), .rst_n(rst_n), .async_i(meter_i),
        .level_o(meter_lvl), .rise_o(meter_rise)
    );

    prover_edge_sync #(.STAGES(SYNC_STAGES)) u_det_sync (
        .clk(clk), .rst_n(rst_n), .async_i(detector_i),
        .level_o(det_lvl), .rise_o(det_rise)
    );

    prover_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en_i),
        .meter_rise_i(meter_rise), .det_rise_i(det_rise),
        .clr_o(cnt_clr), .inc_o(cnt_inc),
        .running_o(running_o), .finished_o(finished_o)
    );

    prover_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
        .count_o(run_count_o), .ovf_o(overflow_o)
    );

    logic unused_lvl;
    assign unused_lvl = meter_lvl ^ det_lvl;
endmodule

// File: rtl/prover_gate_counter_chk.sv
module prover_gate_counter_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_en_i,
    input logic [CNT_W-1:0] run_count_o,
    input logic             running_o,
    input logic             finished_o,
    input logic             overflow_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_count_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (finished_o && gate_en_i) |=> (finished_o && $stable(run_count_o)));

    assert_gate_drop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en_i |=> (!finished_o && !running_o));

    assert_count_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |=> (run_count_o >= $past(run_count_o)));

    assert_finish_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(finished_o) |-> $past(running_o));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (run_count_o == TOP));

    assert_armed_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !finished_o && gate_en_i && $past(gate_en_i)) |=>
            (running_o || $stable(run_count_o)));
endmodule

bind prover_gate_counter prover_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en_i),
    .run_count_o(run_count_o), .running_o(running_o),
    .finished_o(finished_o), .overflow_o(overflow_o)
);

// File: tb/prover_gate_counter_tb.sv
module prover_gate_counter_tb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned CW = 8;
    localparam int unsigned TOPV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_en = 1'b0, meter = 1'b0, det = 1'b0;
    logic [CW-1:0] cnt;
    logic running, finished, ovf;
    int n_total = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prover_gate_counter #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en),
        .meter_i(meter), .detector_i(det),
        .run_count_o(cnt), .running_o(running),
        .finished_o(finished), .overflow_o(ovf)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic m, input logic d);
        meter = m; det = d; tick(2);
        meter = 1'b0; det = 1'b0; tick(2);
    endtask

    task automatic arm();
        gate_en = 1'b0; tick(2);
        gate_en = 1'b1; tick(3);
    endtask

    task automatic t_reset();
        tick(1);
        chk("R1", "count", int'(cnt), 0);
        chk("R1", "running", int'(running), 0);
        chk("R1", "finished", int'(finished), 0);
        chk("R1", "overflow", int'(ovf), 0);
        rst_n = 1'b1; tick(2);
    endtask

    task automatic t_armed_ignore();
        arm();
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        tick(1);
        chk("R2", "count while armed", int'(cnt), 0);
        chk("R2", "running while armed", int'(running), 0);
    endtask

    task automatic t_basic_run();
        arm();
        pulse(1'b0, 1'b1);
        tick(1);
        chk("R3", "running after start", int'(running), 1);
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
        meter = 1'b1; tick(10); meter = 1'b0; tick(3);
        chk("R4", "count five plus held level", int'(cnt), 6);
        pulse(1'b0, 1'b1);
        tick(1);
        chk("R5", "finished", int'(finished), 1);
        chk("R5", "running cleared", int'(running), 0);
        chk("R5", "final count", int'(cnt), 6);
    endtask

    task automatic t_latency();
        arm();
        pulse(1'b0, 1'b1); tick(1);
        @(negedge clk); meter = 1'b1;
        @(negedge clk);
        chk("R4", "no change after one edge", int'(cnt), 0);
        @(negedge clk);
        chk("R4", "no change after two edges", int'(cnt), 0);
        @(negedge clk);
        chk("R4", "count at third edge", int'(cnt), 1);
        meter = 1'b0; tick(3);
        gate_en = 1'b0; tick(2);
    endtask

    task automatic t_coincident();
        arm();
        pulse(1'b1, 1'b1);
        tick(1);
        chk("R3", "start-edge meter not counted", int'(cnt), 0);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        tick(1);
        chk("R5", "stop-edge meter counted", int'(cnt), 4);
        chk("R5", "finished at stop", int'(finished), 1);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b1);
        tick(1);
        chk("R6", "count held after done", int'(cnt), 4);
        chk("R6", "finished held", int'(finished), 1);
        chk("R6", "no new run without toggle", int'(running), 0);
    endtask

    task automatic t_abort_restart();
        arm();
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
        gate_en = 1'b0; tick(1);
        chk("R7", "running cleared on abort", int'(running), 0);
        chk("R7", "finished low on abort", int'(finished), 0);
        chk("R7", "count kept in idle", int'(cnt), 2);
        pulse(1'b1, 1'b0); pulse(1'b0, 1'b1); tick(1);
        chk("R7", "idle ignores pulses", int'(cnt), 2);
        gate_en = 1'b1; tick(2);
        chk("R7", "re-arm clears count", int'(cnt), 0);
        gate_en = 1'b0; tick(2);
    endtask

    task automatic t_overflow();
        arm();
        pulse(1'b0, 1'b1);
        for (int i = 0; i < int'(TOPV) - 1; i++) pulse(1'b1, 1'b0);
        tick(1);
        chk("R8", "one below top no overflow", int'(ovf), 0);
        pulse(1'b1, 1'b0); tick(1);
        chk("R8", "reach top", int'(cnt), int'(TOPV));
        chk("R8", "no overflow at top", int'(ovf), 0);
        pulse(1'b1, 1'b0); pulse(1'b1, 1'b0); tick(1);
        chk("R8", "saturated", int'(cnt), int'(TOPV));
        chk("R8", "overflow set", int'(ovf), 1);
        pulse(1'b0, 1'b1); tick(1);
        chk("R8", "overflow kept in done", int'(ovf), 1);
        arm();
        chk("R7", "re-arm clears overflow", int'(ovf), 0);
        gate_en = 1'b0; tick(2);
    endtask

    initial begin
        t_reset();
        t_armed_ignore();
        t_basic_run();
        t_latency();
        t_coincident();
        t_abort_restart();
        t_overflow();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule